// File: doc/BRIEF.md
# Four-Product Multiply-Add with Round and Saturate

This block takes four operand pairs, multiplies each pair, and adds the four products. The adds run in two stages: two first-stage adders each combine one pair of products, and a pipeline register bank holds those two partial sums. A second-stage adder then combines the partial sums. The total then passes through a rounding step and a clamping step, and the output register bank captures the result word and an overflow flag. It is meant for one- and two-dimensional filter taps, where four coefficient-sample products feed one output sample.

Two runtime controls set the signedness of the operands. One control covers all four A operands and the other covers all four B operands. Each operand is extended by one bit according to its control, so one signed 19×19 multiplier per lane covers all four sign combinations. Operands narrower than the 18-bit lane are carried sign- or zero-extended into the lane. The rounding, clamping and signedness controls travel down the pipeline with their operands. A single clock enable advances both register banks, and an asynchronous clear empties them. There is no state machine beyond the two register banks. Each bank has two states, cleared and loaded, and it moves from one to the other on the clear input or on an enabled clock edge.

Top module: `fma4_sum`

## Requirements
- R1: When `a_signed` is 1, every A operand is read as two's complement. When it is 0, every A operand is read as an unsigned value. A product of two unsigned operands is never negative.
- R2: `b_signed` sets how the B operands are read, in the same way that `a_signed` does for the A operands.
- R3: The full-precision total is the sum of the four lane products. Let TRUNC be the truncation point (default 8). With rounding off, the output value is the full-precision total arithmetically shifted right by TRUNC bits, which rounds toward minus infinity.
- R4: A result appears on `result` after exactly two enabled rising clock edges following the cycle in which its operands are presented. After one such edge, `result` still shows the previous result.
- R5: While `ce` is 0, `result` and `overflow` hold their values, whatever the data and control inputs do.
- R6: Asserting `clr` sets `result` and `overflow` to 0 at once, without waiting for a clock edge. The pipeline bank is cleared as well.
- R7: When `round_en` is 1, the value 2^(TRUNC-1) is added to the total before the shift. A tie therefore rounds upward: a total of +128 gives 1, and a total of -128 gives 0.
- R8: When `sat_en` is 1 and the shifted value falls outside the signed RES_W-bit range, `result` is clamped. It becomes 0x7FFFFF above the range and 0x800000 below it. `overflow` is 1 in the same registered cycle. When the value fits, or when `sat_en` is 0, `overflow` is 0.
- R9: When `sat_en` is 0, `result` holds the low RES_W bits of the shifted value, which wrap on overflow.
- R10: A 16-bit signed operand, sign-extended into its 18-bit lane, gives the same result as its true value.
- R11: The `round_en`, `sat_en` and signedness controls are sampled together with their operands. Changing them one cycle later does not affect that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for both register banks |
| op_a | input | 4×18 | A operands, lane k in bits [18k+17:18k] |
| op_b | input | 4×18 | B operands, same layout |
| a_signed | input | 1 | 1: A operands are two's complement |
| b_signed | input | 1 | 1: B operands are two's complement |
| round_en | input | 1 | Enables round-half-up at the truncation point |
| sat_en | input | 1 | Enables clamping to the output range |
| result | output | 24 | Registered result word, two's complement |
| overflow | output | 1 | Registered flag: result was clamped |

## Verification
The assertions check four things on every cycle. An idle clock enable freezes both outputs. A raised overflow always comes with a clamp value at the output. Overflow can rise only when saturation was in force for that operand set. Unsigned-by-unsigned partial sums never go negative. The bench scenarios cover what a cycle-local property cannot show: the numeric value of each sign combination, the direction of ties under rounding, wrap against clamp at both range ends, the two-edge latency, controls staying aligned with their operands, and the asynchronous effect of the clear.

// File: rtl/fma4_pkg.sv
`timescale 1ns/1ps
package fma4_pkg;

    // Operand sign mode, {A signed, B signed}
    typedef enum logic [1:0] {
        SM_UU = 2'b00,
        SM_US = 2'b01,
        SM_SU = 2'b10,
        SM_SS = 2'b11
    } sign_mode_e;

    function automatic sign_mode_e mode_of(input logic sa, input logic sb);
        return sign_mode_e'({sa, sb});
    endfunction

endpackage

// File: rtl/fma4_lane_pair.sv
`timescale 1ns/1ps
// Two extended multipliers and the first-stage adder for one product pair.
module fma4_lane_pair
    import fma4_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic [1:0][AW-1:0]        a_i,
    input  logic [1:0][AW-1:0]        b_i,
    input  sign_mode_e                mode_i,
    output logic signed [2*AW+2:0]    psum_o
);
    localparam int XW = AW + 1;        // extended operand width
    localparam int MW = 2 * XW;        // product width
    localparam int PW = MW + 1;        // pair sum width

    logic ext_a, ext_b;
    logic signed [MW-1:0] prod [2];

    always_comb begin
        unique case (mode_i)
            SM_SS:   {ext_a, ext_b} = 2'b11;
            SM_SU:   {ext_a, ext_b} = 2'b10;
            SM_US:   {ext_a, ext_b} = 2'b01;
            default: {ext_a, ext_b} = 2'b00;
        endcase
    end

    for (genvar k = 0; k < 2; k++) begin : g_mul
        logic signed [XW-1:0] ax, bx;
        assign ax = {ext_a & a_i[k][AW-1], a_i[k]};
        assign bx = {ext_b & b_i[k][AW-1], b_i[k]};
        assign prod[k] = MW'(ax) * MW'(bx);
    end

    assign psum_o = PW'(prod[0]) + PW'(prod[1]);

endmodule

// File: rtl/fma4_round_sat.sv
`timescale 1ns/1ps
// Round-half-up at a truncation point, then optional clamp to RES_W bits.
module fma4_round_sat #(
    parameter int IN_W  = 40,
    parameter int TRUNC = 8,
    parameter int RES_W = 24
) (
    input  logic signed [IN_W-1:0] sum_i,
    input  logic                   rnd_en,
    input  logic                   sat_en,
    output logic [RES_W-1:0]       res_o,
    output logic                   ovf_o
);
    localparam int BW   = IN_W + 1;
    localparam int SH_W = BW - TRUNC;
    localparam logic [RES_W-1:0] MAXV = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] MINV = {1'b1, {(RES_W-1){1'b0}}};

    logic signed [BW-1:0]   biased;
    logic signed [SH_W-1:0] shifted;
    logic                   fits;
    logic [RES_W-1:0]       plain;

    if (TRUNC > 0) begin : g_rnd
        always_comb begin
            biased = {sum_i[IN_W-1], sum_i};
            if (rnd_en)
                biased = biased + (BW'(1) <<< (TRUNC - 1));
        end
    end else begin : g_nornd
        assign biased = {sum_i[IN_W-1], sum_i};
    end

    assign shifted = SH_W'(biased >>> TRUNC);

    if (SH_W > RES_W) begin : g_chk
        logic [SH_W-RES_W:0] upper;
        assign upper = shifted[SH_W-1:RES_W-1];
        assign fits  = (&upper) | ~(|upper);
        assign plain = shifted[RES_W-1:0];
    end else begin : g_wide
        assign fits  = 1'b1;
        assign plain = RES_W'(shifted);
    end

    always_comb begin
        if (sat_en && !fits) begin
            res_o = shifted[SH_W-1] ? MINV : MAXV;
            ovf_o = 1'b1;
        end else begin
            res_o = plain;
            ovf_o = 1'b0;
        end
    end

endmodule

// File: rtl/fma4_sum.sv
`timescale 1ns/1ps
// Four-product multiply-add: lane pairs -> pipeline bank -> second adder
// -> round/saturate -> output bank.
module fma4_sum
    import fma4_pkg::*;
#(
    parameter int AW    = 18,
    parameter int TRUNC = 8,
    parameter int RES_W = 24
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                ce,
    input  logic [3:0][AW-1:0]  op_a,
    input  logic [3:0][AW-1:0]  op_b,
    input  logic                a_signed,
    input  logic                b_signed,
    input  logic                round_en,
    input  logic                sat_en,
    output logic [RES_W-1:0]    result,
    output logic                overflow
);
    localparam int NPAIR = 2;
    localparam int PW    = 2 * (AW + 1) + 1;
    localparam int SW    = PW + 1;
    localparam logic [RES_W-1:0] MAXV = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] MINV = {1'b1, {(RES_W-1){1'b0}}};

    sign_mode_e mode;
    assign mode = mode_of(a_signed, b_signed);

    logic signed [PW-1:0] psum   [NPAIR];
    logic signed [PW-1:0] psum_q [NPAIR];
    logic                 rnd_q, sat_q;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        fma4_lane_pair #(.AW(AW)) u_pair (
            .a_i    (op_a[2*p+1:2*p]),
            .b_i    (op_b[2*p+1:2*p]),
            .mode_i (mode),
            .psum_o (psum[p])
        );
    end

    // Pipeline register bank
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            psum_q[0] <= '0;
            psum_q[1] <= '0;
            rnd_q     <= 1'b0;
            sat_q     <= 1'b0;
        end else if (ce) begin
            psum_q[0] <= psum[0];
            psum_q[1] <= psum[1];
            rnd_q     <= round_en;
            sat_q     <= sat_en;
        end
    end

    // Second-stage adder and round/saturate
    logic signed [SW-1:0] total;
    logic [RES_W-1:0]     res_d;
    logic                 ovf_d;

    assign total = SW'(psum_q[0]) + SW'(psum_q[1]);

    fma4_round_sat #(.IN_W(SW), .TRUNC(TRUNC), .RES_W(RES_W)) u_rs (
        .sum_i  (total),
        .rnd_en (rnd_q),
        .sat_en (sat_q),
        .res_o  (res_d),
        .ovf_o  (ovf_d)
    );

    // Output register bank
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            result   <= '0;
            overflow <= 1'b0;
        end else if (ce) begin
            result   <= res_d;
            overflow <= ovf_d;
        end
    end

    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (clr)
        !ce |=> ($stable(result) && $stable(overflow))); // R5

    AST_OVF_CLAMPED: assert property (@(posedge clk) disable iff (clr)
        overflow |-> (result == MAXV || result == MINV)); // R8

    AST_OVF_NEEDS_SAT: assert property (@(posedge clk) disable iff (clr)
        $rose(overflow) |-> $past(sat_q)); // R8

    AST_UU_NONNEG: assert property (@(posedge clk) disable iff (clr)
        (ce && !a_signed && !b_signed) |=> (!psum_q[0][PW-1] && !psum_q[1][PW-1])); // R1

endmodule

// File: tb/test_fma4_sum.sv
`timescale 1ns/1ps
module test_fma4_sum;
    localparam int AW = 18, TRUNC = 8, RES_W = 24;

    logic clk = 1'b0, clr = 1'b1, ce = 1'b0;
    logic [3:0][AW-1:0] op_a = '0, op_b = '0;
    logic a_signed = 0, b_signed = 0, round_en = 0, sat_en = 0;
    logic [RES_W-1:0] result;
    logic overflow;

    int n_checks = 0, n_fail = 0;
    logic [RES_W-1:0] prev_res = '0;
    logic             prev_ovf = 1'b0;

    always #2.5 clk = ~clk;

    fma4_sum #(.AW(AW), .TRUNC(TRUNC), .RES_W(RES_W)) i_fma4_sum (.*);

    task automatic check(input string req, input logic [RES_W-1:0] act_r, input logic act_o,
                         input logic [RES_W-1:0] exp_r, input logic exp_o);
        n_checks++;
        if (act_r !== exp_r || act_o !== exp_o) begin
            n_fail++;
            $display("FAIL %s: result=%h overflow=%b expected result=%h overflow=%b",
                     req, act_r, act_o, exp_r, exp_o);
        end
    endtask

    function automatic void model(input logic [3:0][AW-1:0] a, input logic [3:0][AW-1:0] b,
                                  input logic sa, input logic sb, input logic rnd, input logic sat,
                                  output logic [RES_W-1:0] r, output logic o);
        longint s = 0;
        for (int k = 0; k < 4; k++) begin
            longint x, y;
            x = sa ? longint'($signed(a[k])) : longint'({46'd0, a[k]});
            y = sb ? longint'($signed(b[k])) : longint'({46'd0, b[k]});
            s += x * y;
        end
        if (rnd) s += 64'sd1 <<< (TRUNC - 1);
        s = s >>> TRUNC;
        o = 1'b0;
        r = s[RES_W-1:0];
        if (sat && s > 64'sd8388607)       begin r = 24'h7FFFFF; o = 1'b1; end
        else if (sat && s < -64'sd8388608) begin r = 24'h800000; o = 1'b1; end
    endfunction

    // Present one operand set, check latency and final value.
    task automatic run_op(input string req, input logic [3:0][AW-1:0] a, input logic [3:0][AW-1:0] b,
                          input logic sa, input logic sb, input logic rnd, input logic sat);
        logic [RES_W-1:0] er; logic eo;
        model(a, b, sa, sb, rnd, sat, er, eo);
        @(negedge clk);
        op_a = a; op_b = b; a_signed = sa; b_signed = sb; round_en = rnd; sat_en = sat; ce = 1;
        @(negedge clk);
        check("R4 one-edge hold", result, overflow, prev_res, prev_ovf);
        @(negedge clk);
        check(req, result, overflow, er, eo);
        prev_res = er; prev_ovf = eo;
    endtask

    task automatic t_reset;
        check("R6 reset state", result, overflow, '0, 1'b0);
    endtask

    task automatic t_signs;
        logic [3:0][AW-1:0] a = '0, b = '0;
        a[0] = 18'h3FFFF; b[0] = 18'd2000;
        a[2] = 18'd5000;  b[2] = 18'h3FF00;
        run_op("R1 R2 UU", a, b, 0, 0, 0, 0);
        run_op("R1 SU",    a, b, 1, 0, 0, 0);
        run_op("R2 US",    a, b, 0, 1, 0, 0);
        run_op("R1 R2 SS", a, b, 1, 1, 0, 0);
    endtask

    task automatic t_sum;
        logic [3:0][AW-1:0] a, b;
        a = {18'd300, 18'h3FF38, 18'd7, 18'd12345};
        b = {18'd1000, 18'd999, 18'h3F000, 18'd77};
        run_op("R3 four-lane sum", a, b, 1, 1, 0, 0);
    endtask

    task automatic t_round;
        logic [3:0][AW-1:0] a = '0, b = '0;
        a[1] = 18'd1; b[1] = 18'd128;
        run_op("R7 positive tie rounds up", a, b, 0, 0, 1, 0);
        run_op("R3 positive tie floor", a, b, 0, 0, 0, 0);
        a[1] = 18'h3FFFF;
        run_op("R7 negative tie rounds up", a, b, 1, 0, 1, 0);
        run_op("R3 negative tie floor", a, b, 1, 0, 0, 0);
    endtask

    task automatic t_sat;
        logic [3:0][AW-1:0] a, b;
        a = {4{18'h20000}}; b = {4{18'h1FFFF}};
        run_op("R8 clamp to minimum", a, b, 1, 1, 0, 1);
        run_op("R9 wrap without saturation", a, b, 1, 1, 0, 0);
        a = {4{18'h3FFFF}}; b = {4{18'h3FFFF}};
        run_op("R8 clamp to maximum", a, b, 0, 0, 1, 1);
        run_op("R9 wrap unsigned", a, b, 0, 0, 1, 0);
        a = {4{18'd100}}; b = {4{18'd100}};
        run_op("R8 in range no overflow", a, b, 0, 0, 0, 1);
    endtask

    task automatic t_pad;
        logic [3:0][AW-1:0] a = '0, b = '0;
        a[3] = {{2{1'b1}}, 16'hFC18};   // -1000 as 16 bits, extended
        b[3] = 18'd3000;
        run_op("R10 padded 16-bit operand", a, b, 1, 1, 0, 0);
        n_checks++;
        if (result !== 24'(-(1000 * 3000) >>> TRUNC)) begin
            n_fail++;
            $display("FAIL R10: result=%h expected=%h", result, 24'(-(1000 * 3000) >>> TRUNC));
        end
    endtask

    task automatic t_ctrl_align;
        logic [3:0][AW-1:0] a = '0, b = '0;
        logic [RES_W-1:0] er; logic eo;
        a[0] = 18'd1; b[0] = 18'd128;
        model(a, b, 0, 0, 1, 0, er, eo);
        @(negedge clk);
        op_a = a; op_b = b; a_signed = 0; b_signed = 0; round_en = 1; sat_en = 0; ce = 1;
        @(negedge clk);
        op_a = '0; op_b = '0; round_en = 0; a_signed = 1;
        @(negedge clk);
        check("R11 controls travel with operands", result, overflow, er, eo);
        @(negedge clk);
        check("R11 following zero set", result, overflow, '0, 1'b0);
        prev_res = '0; prev_ovf = 0;
    endtask

    task automatic t_ce_hold;
        logic [3:0][AW-1:0] a = {4{18'h3FFFF}}, b = {4{18'h3FFFF}};
        logic [RES_W-1:0] er; logic eo;
        logic [RES_W-1:0] held_r; logic held_o;
        run_op("R8 load before hold", a, b, 0, 0, 0, 1);
        held_r = result; held_o = overflow;
        @(negedge clk);
        ce = 0; op_a = {4{18'd3}}; op_b = {4{18'd5}}; sat_en = 0;
        repeat (4) @(negedge clk);
        check("R5 hold while ce low", result, overflow, held_r, held_o);
        model({4{18'd3}}, {4{18'd5}}, 0, 0, 0, 0, er, eo);
        ce = 1;
        @(negedge clk);
        @(negedge clk);
        check("R4 R5 resume after ce", result, overflow, er, eo);
        prev_res = er; prev_ovf = eo;
    endtask

    task automatic t_clear;
        logic [3:0][AW-1:0] a = {4{18'h20000}}, b = {4{18'h1FFFF}};
        run_op("R8 load before clear", a, b, 1, 1, 0, 1);
        @(negedge clk);
        #1 clr = 1;
        #0.5 check("R6 asynchronous clear", result, overflow, '0, 1'b0);
        @(negedge clk);
        clr = 0; ce = 0;
        @(negedge clk);
        ce = 1;
        op_a = '0; op_b = '0;
        @(negedge clk);
        check("R6 pipeline bank cleared", result, overflow, '0, 1'b0);
        prev_res = '0; prev_ovf = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        clr = 0;
        t_signs();
        t_sum();
        t_round();
        t_sat();
        t_pad();
        t_ctrl_align();
        t_ce_hold();
        t_clear();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule